// File: doc/BRIEF.md
# Filtered Port Request Detector

This block watches a small group of active-low request pins and latches one request flag per pin. Each pin has its own two-bit mode field. The mode picks how a request is accepted. Mode 00 accepts a single falling edge. The other modes accept a low level only after sixteen consecutive low samples. Those samples are taken on strobes that divide the system clock by 8, 16 or 128, depending on the mode. A request counts only when the pin has stayed low for a whole window, so short glitches are rejected.

All pins pass through a two-flop synchronizer before edge detection or sampling. Software reads and writes the block through a small register port. Address 0 holds the mode fields and an interrupt enable. Address 1 holds the flags. The flags are ORed together and gated by the enable to form a single interrupt request. A flag stays set until software has read it as 1 and then writes 0 to it.

Top module: `port_req_detect`

## Requirements
- R1: After reset all mode fields are 00, the interrupt enable is 0, all flags are 0 and `irq` is 0.
- R2: At address 0, bits [2k+1:2k] hold the mode of pin k and bit 8 holds the interrupt enable. Bits 15:9 always read 0, and writing them has no effect. Writing 0xFFFF reads back as 0x01FF.
- R3: In mode 00, a high-to-low change on pin k sets flag k. When the pin is driven at a negative clock edge, the flag reads 1 at the third following negative edge and 0 at the second. A pin that stays low, or rises, sets nothing more.
- R4: In mode 01, flag k sets only after 16 consecutive low samples taken every 8 clocks. It is still 0 at 15×8 clocks after the pin goes low, it is 1 by 17×8+4 clocks, and a low pulse of 14×8 clocks never sets it.
- R5: Mode 10 follows the same rule with one sample every 16 clocks, using the windows 15×16, 17×16+4 and 14×16.
- R6: Mode 11 follows the same rule with one sample every 128 clocks, using the windows 15×128, 17×128+4 and 14×128.
- R7: Writing 0 to bit k of address 1 clears flag k only if flag k was read as 1 since the last write to address 1. Writing 1 never changes a flag. A flag changes only when it is cleared or when its pin raises a request.
- R8: `irq` equals the enable bit ANDed with the OR of all flags.
- R9: At address 1, bits [3:0] hold flags 3..0 and the upper bits read 0. A request on one pin sets no other pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the sampling strobes are derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; arms the clear of flags that read as 1 |
| addr | input | 1 | Register select: 0 for control, 1 for flags |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| pins_n | input | 4 | Asynchronous active-low request pins |
| irq | output | 1 | Interrupt request |

## Verification
Five properties are checked on every cycle. A flag never falls except after a write to the flag register. A write of all ones never clears a flag. Any rising flag is traced back to a low pin three cycles earlier. `irq` never rises without the enable. No filter counter goes past sixteen.

Only the bench scenarios can show the exact acceptance timing. For each pin and each mode, the bench checks the cycle at which an edge is accepted, the early and late limits of each filter window, and that glitches are rejected. It also checks the read-then-write clear sequence and the masking of the reserved bits.

// File: rtl/port_req_detect.sv
module port_req_detect #(
  parameter int NPINS    = 4,
  parameter int FILT_LEN = 16,
  parameter int DIV_A    = 8,
  parameter int DIV_B    = 16,
  parameter int DIV_C    = 128,
  parameter int DW       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pins_n,
  output logic             irq
);
  localparam int CW     = $clog2(FILT_LEN + 1);
  localparam int PW     = $clog2(DIV_C);
  localparam int EN_BIT = 2 * NPINS;

  logic [PW-1:0]            pre;
  logic                     stb_a, stb_b, stb_c;
  logic [2*NPINS-1:0]       mode;
  logic                     en;
  logic [NPINS-1:0]         sync1, sync2, prev, flag, armed;
  logic [NPINS-1:0][CW-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  assign stb_a = (pre & PW'(DIV_A - 1)) == PW'(DIV_A - 1);
  assign stb_b = (pre & PW'(DIV_B - 1)) == PW'(DIV_B - 1);
  assign stb_c = (pre & PW'(DIV_C - 1)) == PW'(DIV_C - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= '0;
      en   <= 1'b0;
    end else if (wr_en && !addr) begin
      mode <= wdata[2*NPINS-1:0];
      en   <= wdata[EN_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      prev  <= '1;
    end else begin
      sync1 <= pins_n;
      sync2 <= sync1;
      prev  <= sync2;
    end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] m;
    logic       stb, filt_done, edge_hit, clr;
    assign m         = mode[2*i +: 2];
    assign stb       = (m == 2'b01) ? stb_a : (m == 2'b10) ? stb_b : stb_c;
    assign filt_done = (m != 2'b00) && stb && !sync2[i] && (fcnt[i] == CW'(FILT_LEN - 1));
    assign edge_hit  = (m == 2'b00) && prev[i] && !sync2[i];
    assign clr       = wr_en && addr && !wdata[i] && armed[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           fcnt[i] <= '0;
      else if (m == 2'b00)                  fcnt[i] <= '0;
      else if (stb) begin
        if (sync2[i])                       fcnt[i] <= '0;
        else if (fcnt[i] != CW'(FILT_LEN))  fcnt[i] <= fcnt[i] + 1'b1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= edge_hit | filt_done | (flag[i] & ~clr);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                armed[i] <= 1'b0;
      else if (wr_en && addr)    armed[i] <= 1'b0;
      else if (rd_en && addr)    armed[i] <= flag[i];
  end

  assign rdata = addr ? DW'(flag) : DW'({en, mode});
  assign irq   = en & (|flag);
endmodule

// File: rtl/port_req_detect_chk.sv
module port_req_detect_chk #(
  parameter int NPINS    = 4,
  parameter int FILT_LEN = 16,
  parameter int DW       = 16,
  parameter int CW       = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     addr,
  input logic [DW-1:0]            wdata,
  input logic [NPINS-1:0]         pins_n,
  input logic                     irq,
  input logic                     en,
  input logic [NPINS-1:0]         flag,
  input logic [NPINS-1:0][CW-1:0] fcnt
);
  assert_flag_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag & $past(flag)) != '0) |-> $past(wr_en && addr));

  assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr && (wdata[NPINS-1:0] == '1)) |-> ((flag & $past(flag)) == $past(flag)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_flag_from_low_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ($past(pins_n[i], 3) == 1'b0));

    assert_no_count_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt[i] <= CW'(FILT_LEN));
  end
endmodule

bind port_req_detect port_req_detect_chk #(
  .NPINS(NPINS), .FILT_LEN(FILT_LEN), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pins_n(pins_n), .irq(irq), .en(en), .flag(flag), .fcnt(fcnt)
);

// File: tb/port_req_detect_tb.sv
module port_req_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pins_n = 4'hF;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  port_req_detect u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_n(pins_n), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] v;
    rd(1'b1, v);
    wr(1'b1, 16'h0000);
  endtask

  task automatic peek_flags(output logic [15:0] d);
    addr = 1'b1;
    #1 d = rdata;
    addr = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    int div;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);

    rd(1'b0, v); chk("R1 ctrl reset", v, 16'h0000);
    rd(1'b1, v); chk("R1 flags reset", v, 16'h0000);
    chk("R1 irq reset", irq, 1'b0);

    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); chk("R2 reserved bits", v, 16'h01FF);
    wr(1'b0, 16'h0000);

    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic e;
        e = k[0] ^ m[0];
        wr(1'b0, 16'({e, 8'(m << (2*k))}));
        clear_all();
        wait_n(2);
        peek_flags(v); chk("R9 flags clear before stimulus", v, 16'h0000);
        pins_n[k] = 1'b0;
        if (m == 0) begin
          wait_n(2);
          peek_flags(v); chk("R3 no flag at second edge", v, 16'h0000);
          wait_n(1);
          peek_flags(v); chk("R3 flag at third edge", v, 16'(1 << k));
          chk("R8 irq", irq, e);
          clear_all();
          wait_n(10);
          peek_flags(v); chk("R3 steady low sets nothing", v, 16'h0000);
          pins_n[k] = 1'b1;
          wait_n(5);
          peek_flags(v); chk("R3 rising sets nothing", v, 16'h0000);
          chk("R8 irq low with no flag", irq, 1'b0);
        end else begin
          div = (m == 1) ? 8 : (m == 2) ? 16 : 128;
          wait_n(15 * div);
          peek_flags(v);
          chk(m == 1 ? "R4 early window" : m == 2 ? "R5 early window" : "R6 early window", v, 16'h0000);
          wait_n(2 * div + 4);
          peek_flags(v);
          chk(m == 1 ? "R4 late window" : m == 2 ? "R5 late window" : "R6 late window", v, 16'(1 << k));
          chk("R8 irq", irq, e);
          pins_n[k] = 1'b1;
          wait_n(3);
          clear_all();
          pins_n[k] = 1'b0;
          wait_n(14 * div);
          pins_n[k] = 1'b1;
          wait_n(2 * div);
          peek_flags(v);
          chk(m == 1 ? "R4 glitch rejected" : m == 2 ? "R5 glitch rejected" : "R6 glitch rejected", v, 16'h0000);
        end
      end
    end

    wr(1'b0, 16'h0100);
    clear_all();
    pins_n[2] = 1'b0;
    wait_n(4);
    pins_n[2] = 1'b1;
    wr(1'b1, 16'h0000);
    peek_flags(v); chk("R7 write 0 without read keeps flag", v, 16'h0004);
    rd(1'b1, v);
    wr(1'b1, 16'hFFFF);
    peek_flags(v); chk("R7 write 1 keeps flag", v, 16'h0004);
    chk("R8 irq with enable", irq, 1'b1);
    rd(1'b1, v);
    wr(1'b1, 16'h0000);
    peek_flags(v); chk("R7 read then write 0 clears", v, 16'h0000);
    chk("R8 irq after clear", irq, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule